// File: doc/BRIEF.md
# Partition-Aware Victim Selector

This block picks the line to replace in one set of a shared cache whose ways are split among several cores by per-core quotas. For each request it receives the whole set's state: one valid bit, one owner field and one recency rank per way. It also receives the requesting core's identity, a hit flag with the hit way, and a vector of per-core way quotas. One cycle later it returns the way it touched, together with the rewritten owner fields and recency ranks for the whole set. The tag array writes these back.

On a miss, an empty way is always used first. When the set is full, the block counts the valid lines that the requester owns in this set. While that count is below the requester's quota, the requester takes the least-recent line of some other core. Once the count reaches the quota, the requester recycles its own least-recent line. If the chosen group holds no lines, the least-recent line of the whole set is used instead. A change of quota moves no lines by itself. A core whose quota grows gains one way per later miss, so the new split builds up gradually.

On a hit the block only refreshes recency. The touched way becomes most recent and every way that was more recent than it ages by one. Tag comparison, the data array and the computation of the quotas happen outside the block.

Top module: `partVictimSel`

## Requirements
- R1: While reset is held and on idle cycles after it, `respValid` is 0.
- R2: Every request with `reqValid` high produces exactly one response with `respValid` high on the following clock edge, and no response appears without a request.
- R3: On a miss in a set holding at least one invalid way, the victim is the lowest-numbered invalid way.
- R4: On a miss in a full set, when the number of valid lines whose owner equals `reqCore` is below that core's quota (`coreQuota[c*5 +: 5]` for core c), the victim is the line with the highest rank among lines owned by other cores.
- R5: On a miss in a full set, when that count is equal to or above the quota, the victim is the line with the highest rank among the requester's own lines.
- R6: If the group selected by R4 or R5 is empty, the victim is the line with the highest rank in the whole set. A quota of 0 or a quota above the way count are both legal.
- R7: On a miss, `respFill` is 1 and `respWay` is the victim. The victim's owner becomes `reqCore` and its rank becomes 0. Every way whose rank was below the victim's old rank gains one. All other fields are unchanged.
- R8: On a hit, `respFill` is 0 and `respWay` equals `reqHitWay`. All owner fields are returned unchanged. Ranks are updated as in R7 with the hit way as the touched way.
- R9: A quota change by itself rewrites no owner field. A miss rewrites at most one owner field, so a larger quota is taken up one way per miss.
- R10: Way i's owner field sits at bits `[i*CORE_W +: CORE_W]` and its rank at `[i*4 +: 4]`. Rank 0 is most recent and rank 15 least recent. The returned ranks always form a permutation of 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqHit | input | 1 | 1 = hit update, 0 = miss fill |
| reqHitWay | input | 4 | Way that hit (used when reqHit is 1) |
| reqCore | input | CORE_W (1) | Requesting core |
| setValid | input | 16 | Valid bit per way |
| setOwner | input | 16*CORE_W | Owner field per way |
| setRank | input | 64 | Recency rank per way |
| coreQuota | input | NUM_CORES*5 | Way quota per core |
| respValid | output | 1 | Response present |
| respFill | output | 1 | Response is a fill |
| respWay | output | 4 | Touched way (victim or hit way) |
| respOwner | output | 16*CORE_W | Updated owner fields |
| respRank | output | 64 | Updated recency ranks |

## Verification
The assertions assume three things about the inputs. The incoming ranks are a permutation of 0 to 15. `reqCore` names an existing core. A hit names a valid way. The permutation check and the rank-0 check on the touched way are meaningful only under these assumptions. The bench keeps its own shadow of the set state and drives every request from that shadow. It loads only permutations, and it issues hits only to ways the shadow marks valid. Random quotas range from 0 to 20, so quotas of zero and quotas above the way count are both exercised.

// File: rtl/partVictimPkg.sv
package partVictimPkg;
  // Strobes from the control to the datapath: which candidate group to use
  // and whether the request is a fill or only a recency touch.
  typedef struct packed {
    logic selInvalid;
    logic selOthers;
    logic selOwn;
    logic selAll;
    logic doFill;
    logic doTouch;
  } victimStrobes_t;
endpackage

// File: rtl/partVictimCtrl.sv
module partVictimCtrl
  import partVictimPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqHit,
  input  logic           anyInvalid,
  input  logic           underQuota,
  input  logic           anyOwn,
  input  logic           anyOther,
  output victimStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    if (reqValid) begin
      strobes.doTouch = 1'b1;
      if (!reqHit) begin
        strobes.doFill = 1'b1;
        if (anyInvalid)           strobes.selInvalid = 1'b1;
        else if (underQuota) begin
          if (anyOther)           strobes.selOthers  = 1'b1;
          else                    strobes.selAll     = 1'b1;
        end else begin
          if (anyOwn)             strobes.selOwn     = 1'b1;
          else                    strobes.selAll     = 1'b1;
        end
      end
    end
  end

  // R6: at most one candidate group is active at a time
  assert_one_group_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.selInvalid, strobes.selOthers, strobes.selOwn, strobes.selAll}));

  // R8: a hit selects no eviction group
  assert_hit_no_group_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqHit) |->
      !(strobes.selInvalid || strobes.selOthers || strobes.selOwn || strobes.selAll));

endmodule

// File: rtl/partVictimPath.sv
module partVictimPath
  import partVictimPkg::*;
#(
  parameter  int NUM_WAYS  = 16,
  parameter  int NUM_CORES = 2,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int RW = $clog2(NUM_WAYS),
  localparam int WW = $clog2(NUM_WAYS),
  localparam int QW = $clog2(NUM_WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  victimStrobes_t          strobes,
  input  logic [WW-1:0]           reqHitWay,
  input  logic [CW-1:0]           reqCore,
  input  logic [NUM_WAYS-1:0]     setValid,
  input  logic [NUM_WAYS*CW-1:0]  setOwner,
  input  logic [NUM_WAYS*RW-1:0]  setRank,
  input  logic [NUM_CORES*QW-1:0] coreQuota,
  output logic                    anyInvalid,
  output logic                    underQuota,
  output logic                    anyOwn,
  output logic                    anyOther,
  output logic                    respValid,
  output logic                    respFill,
  output logic [WW-1:0]           respWay,
  output logic [NUM_WAYS*CW-1:0]  respOwner,
  output logic [NUM_WAYS*RW-1:0]  respRank
);

  logic [CW-1:0]          wayOwner [NUM_WAYS];
  logic [RW-1:0]          wayRank  [NUM_WAYS];
  logic [NUM_WAYS-1:0]    ownMask, otherMask, candMask;
  logic [QW-1:0]          ownCount, reqQuota;
  logic [WW-1:0]          firstInvalid, oldestWay, victimWay, touchWay;
  logic [RW-1:0]          oldestRank, touchRank;
  logic                   oldestFound;
  logic [NUM_WAYS*CW-1:0] nextOwner;
  logic [NUM_WAYS*RW-1:0] nextRank;

  // Per-way decode and per-way update
  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_way
    assign wayOwner[i]  = setOwner[i*CW +: CW];
    assign wayRank[i]   = setRank[i*RW +: RW];
    assign ownMask[i]   = setValid[i] && (wayOwner[i] == reqCore);
    assign otherMask[i] = setValid[i] && (wayOwner[i] != reqCore);
    assign nextRank[i*RW +: RW] =
      (touchWay == WW'(i))    ? '0 :
      (wayRank[i] < touchRank) ? wayRank[i] + RW'(1) : wayRank[i];
    assign nextOwner[i*CW +: CW] =
      (strobes.doFill && (victimWay == WW'(i))) ? reqCore : wayOwner[i];
  end

  // Occupancy of the requester in this set against its quota
  always_comb begin
    ownCount = '0;
    for (int i = 0; i < NUM_WAYS; i++) ownCount = ownCount + QW'(ownMask[i]);
  end
  assign reqQuota   = coreQuota[int'(reqCore)*QW +: QW];
  assign underQuota = ownCount < reqQuota;
  assign anyInvalid = !(&setValid);
  assign anyOwn     = |ownMask;
  assign anyOther   = |otherMask;

  // Lowest-numbered empty way
  always_comb begin
    firstInvalid = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--)
      if (!setValid[i]) firstInvalid = WW'(i);
  end

  // Least-recent way inside the selected group
  always_comb begin
    if (strobes.selOthers)   candMask = otherMask;
    else if (strobes.selOwn) candMask = ownMask;
    else if (strobes.selAll) candMask = '1;
    else                     candMask = '0;
  end

  always_comb begin
    oldestFound = 1'b0;
    oldestWay   = '0;
    oldestRank  = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (candMask[i] && (!oldestFound || wayRank[i] > oldestRank)) begin
        oldestFound = 1'b1;
        oldestWay   = WW'(i);
        oldestRank  = wayRank[i];
      end
    end
  end

  assign victimWay = strobes.selInvalid ? firstInvalid : oldestWay;
  assign touchWay  = strobes.doFill ? victimWay : reqHitWay;
  assign touchRank = wayRank[touchWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respFill  <= 1'b0;
      respWay   <= '0;
      respOwner <= '0;
      respRank  <= '0;
    end else begin
      respValid <= strobes.doTouch;
      if (strobes.doTouch) begin
        respFill  <= strobes.doFill;
        respWay   <= touchWay;
        respOwner <= nextOwner;
        respRank  <= nextRank;
      end
    end
  end

  // ---------------- assertion support: request as seen last cycle ----------
  logic [NUM_WAYS-1:0]    capValid;
  logic [NUM_WAYS*CW-1:0] capOwner;
  logic [CW-1:0]          capCore;
  logic                   capSelOthers, capSelOwn;
  logic [NUM_WAYS-1:0]    rankSeen, ownerDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid     <= '0;
      capOwner     <= '0;
      capCore      <= '0;
      capSelOthers <= 1'b0;
      capSelOwn    <= 1'b0;
    end else if (strobes.doTouch) begin
      capValid     <= setValid;
      capOwner     <= setOwner;
      capCore      <= reqCore;
      capSelOthers <= strobes.selOthers;
      capSelOwn    <= strobes.selOwn;
    end
  end

  always_comb begin
    rankSeen = '0;
    for (int v = 0; v < NUM_WAYS; v++)
      for (int w = 0; w < NUM_WAYS; w++)
        if (respRank[w*RW +: RW] == RW'(v)) rankSeen[v] = 1'b1;
  end

  for (genvar i = 0; i < NUM_WAYS; i++) begin : g_diff
    assign ownerDiff[i] = respOwner[i*CW +: CW] != capOwner[i*CW +: CW];
  end

  assert_resp_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doTouch |=> respValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doTouch |=> !respValid);

  assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFill && !(&capValid)) |-> !capValid[respWay]);

  assert_take_other_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && capSelOthers) |-> (capOwner[respWay*CW +: CW] != capCore));

  assert_take_own_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && capSelOwn) |-> (capOwner[respWay*CW +: CW] == capCore));

  assert_fill_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFill) |-> (respOwner[respWay*CW +: CW] == capCore));

  assert_touch_mru_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respRank[respWay*RW +: RW] == '0));

  assert_hit_keeps_owner_R8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFill) |-> (ownerDiff == '0));

  assert_single_claim_R9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones(ownerDiff) <= 1));

  assert_rank_perm_R10: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (&rankSeen));

endmodule

// File: rtl/partVictimSel.sv
module partVictimSel
  import partVictimPkg::*;
#(
  parameter  int NUM_WAYS  = 16,
  parameter  int NUM_CORES = 2,
  localparam int CW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int RW = $clog2(NUM_WAYS),
  localparam int WW = $clog2(NUM_WAYS),
  localparam int QW = $clog2(NUM_WAYS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqHit,
  input  logic [WW-1:0]           reqHitWay,
  input  logic [CW-1:0]           reqCore,
  input  logic [NUM_WAYS-1:0]     setValid,
  input  logic [NUM_WAYS*CW-1:0]  setOwner,
  input  logic [NUM_WAYS*RW-1:0]  setRank,
  input  logic [NUM_CORES*QW-1:0] coreQuota,
  output logic                    respValid,
  output logic                    respFill,
  output logic [WW-1:0]           respWay,
  output logic [NUM_WAYS*CW-1:0]  respOwner,
  output logic [NUM_WAYS*RW-1:0]  respRank
);

  victimStrobes_t strobes;
  logic anyInvalid, underQuota, anyOwn, anyOther;

  partVictimCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqHit     (reqHit),
    .anyInvalid (anyInvalid),
    .underQuota (underQuota),
    .anyOwn     (anyOwn),
    .anyOther   (anyOther),
    .strobes    (strobes)
  );

  partVictimPath #(.NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reqHitWay  (reqHitWay),
    .reqCore    (reqCore),
    .setValid   (setValid),
    .setOwner   (setOwner),
    .setRank    (setRank),
    .coreQuota  (coreQuota),
    .anyInvalid (anyInvalid),
    .underQuota (underQuota),
    .anyOwn     (anyOwn),
    .anyOther   (anyOther),
    .respValid  (respValid),
    .respFill   (respFill),
    .respWay    (respWay),
    .respOwner  (respOwner),
    .respRank   (respRank)
  );

endmodule

// File: tb/partVictimSel_bench.sv
module partVictimSel_bench;
  localparam int W = 16;
  localparam int C = 2;
  localparam int CW = 1;
  localparam int RW = 4;
  localparam int QW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqHit = 1'b0;
  logic [3:0] reqHitWay = '0;
  logic [CW-1:0] reqCore = '0;
  logic [W-1:0] setValid = '0;
  logic [W*CW-1:0] setOwner = '0;
  logic [W*RW-1:0] setRank = '0;
  logic [C*QW-1:0] coreQuota = '0;
  logic respValid, respFill;
  logic [3:0] respWay;
  logic [W*CW-1:0] respOwner;
  logic [W*RW-1:0] respRank;

  always #4 clk = ~clk;  // 125 MHz

  partVictimSel u_partVictimSel (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
    .reqHitWay(reqHitWay), .reqCore(reqCore), .setValid(setValid),
    .setOwner(setOwner), .setRank(setRank), .coreQuota(coreQuota),
    .respValid(respValid), .respFill(respFill), .respWay(respWay),
    .respOwner(respOwner), .respRank(respRank)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int              way;
    bit              fill;
    logic [W*CW-1:0] owner;
    logic [W*RW-1:0] rank;
    string           tag;
  } exp_t;
  exp_t expQ[$];

  // Shadow of the set state, kept by the bench from the requirements
  bit bValid [W];
  int bOwner [W];
  int bRank  [W];
  int quota  [C];

  function automatic logic [W*CW-1:0] packOwner();
    logic [W*CW-1:0] v;
    for (int i = 0; i < W; i++) v[i*CW +: CW] = CW'(bOwner[i]);
    return v;
  endfunction

  function automatic logic [W*RW-1:0] packRank();
    logic [W*RW-1:0] v;
    for (int i = 0; i < W; i++) v[i*RW +: RW] = RW'(bRank[i]);
    return v;
  endfunction

  // Reference victim choice (R3 to R6)
  function automatic int refVictim(int core);
    int own = 0, best = -1, bestRank = -1;
    bit under;
    for (int i = 0; i < W; i++) if (!bValid[i]) return i;
    for (int i = 0; i < W; i++) if (bOwner[i] == core) own++;
    under = own < quota[core];
    for (int i = 0; i < W; i++)
      if (((under && bOwner[i] != core) || (!under && bOwner[i] == core)) && bRank[i] > bestRank) begin
        best = i; bestRank = bRank[i];
      end
    if (best < 0)
      for (int i = 0; i < W; i++)
        if (bRank[i] > bestRank) begin best = i; bestRank = bRank[i]; end
    return best;
  endfunction

  task automatic doReq(input bit hit, input int hw, input int core, input string tag);
    exp_t e;
    int v, r0;
    @(negedge clk);
    reqValid  = 1'b1;
    reqHit    = hit;
    reqHitWay = 4'(hw);
    reqCore   = CW'(core);
    for (int i = 0; i < W; i++) setValid[i] = bValid[i];
    setOwner  = packOwner();
    setRank   = packRank();
    for (int c = 0; c < C; c++) coreQuota[c*QW +: QW] = QW'(quota[c]);
    v  = hit ? hw : refVictim(core);
    r0 = bRank[v];
    for (int i = 0; i < W; i++)
      if (i == v) bRank[i] = 0;
      else if (bRank[i] < r0) bRank[i] = bRank[i] + 1;
    if (!hit) begin bOwner[v] = core; bValid[v] = 1'b1; end
    e.way = v; e.fill = !hit; e.owner = packOwner(); e.rank = packRank(); e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // Monitor: compares each response with the queued expectation (R2 timing)
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (rstN) begin
        if (respValid) begin
          if (expQ.size() == 0) begin
            checks++; fails++;
            $display("FAIL R2: response without request, respValid=%0b expected 0", respValid);
          end else begin
            e = expQ.pop_front();
            checks++;
            if (respWay != 4'(e.way) || respFill != e.fill) begin
              fails++;
              $display("FAIL %s: way/fill got %0d/%0b expected %0d/%0b", e.tag, respWay, respFill, e.way, e.fill);
            end
            checks++;
            if (respOwner !== e.owner) begin
              fails++;
              $display("FAIL %s: owners got %h expected %h", e.tag, respOwner, e.owner);
            end
            checks++;
            if (respRank !== e.rank) begin
              fails++;
              $display("FAIL %s: ranks got %h expected %h", e.tag, respRank, e.rank);
            end
          end
        end else if (expQ.size() != 0) begin
          checks++; fails++;
          $display("FAIL R2: no response one cycle after request, respValid=0 expected 1");
          void'(expQ.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < W; i++) begin bValid[i] = 0; bOwner[i] = 0; bRank[i] = i; end
    quota[0] = 8; quota[1] = 8;

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin fails++; $display("FAIL R1: respValid in reset got %b expected 0", respValid); end
    rstN = 1'b1;
    idle(2);
    checks++;
    if (respValid !== 1'b0) begin fails++; $display("FAIL R1: respValid idle got %b expected 0", respValid); end

    // R3: cold fill from an empty set, cores alternate; ways 0..15 in order
    for (int i = 0; i < W; i++) doReq(1'b0, 0, i % 2, "R3");

    // R5: core 0 owns 8 with quota 8, recycles its own oldest line
    doReq(1'b0, 0, 0, "R5");

    // R4 / R9: quota of core 0 grows to 10; taken up one way per miss
    quota[0] = 10; quota[1] = 6;
    idle(1);
    doReq(1'b0, 0, 0, "R4");
    doReq(1'b0, 0, 0, "R9");
    doReq(1'b0, 0, 0, "R5");

    // R8: hits refresh recency and keep owners
    doReq(1'b1, 7, 1, "R8");
    doReq(1'b1, 0, 0, "R8");
    doReq(1'b1, 12, 1, "R8");

    // R6: under quota but owns every line; quota above way count
    idle(1);
    for (int i = 0; i < W; i++) bOwner[i] = 0;
    quota[0] = 20; quota[1] = 0;
    doReq(1'b0, 0, 0, "R6");
    // R6: quota 0 and owns nothing -> whole-set oldest
    doReq(1'b0, 0, 1, "R6");

    // R3: holes in a full set are filled lowest first
    idle(1);
    bValid[9] = 0; bValid[5] = 0;
    doReq(1'b0, 0, 1, "R3");
    doReq(1'b0, 0, 0, "R3");

    // R7 / R10: random traffic with changing quotas
    for (int n = 0; n < 600; n++) begin
      if (n % 40 == 0) begin
        quota[0] = $urandom_range(0, 20);
        quota[1] = $urandom_range(0, 20);
      end
      if ($urandom_range(0, 3) == 0) begin
        int hw;
        hw = $urandom_range(0, W - 1);
        doReq(1'b1, hw, $urandom_range(0, C - 1), "R8");
      end else begin
        doReq(1'b0, 0, $urandom_range(0, C - 1), "R7");
      end
      if (n % 97 == 0) idle(1);
    end

    idle(4);
    checks++;
    if (expQ.size() != 0) begin fails++; $display("FAIL R2: %0d responses missing, expected 0", expQ.size()); end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule